// File: doc/BRIEF.md
# Upper Memory Chip-Select Unit

This block decodes the top region of a 20-bit address space and drives an active-low chip select for it. The region always ends at address FFFFFh, and only its lower boundary can be programmed. Every access that falls in the region is stretched by a programmable number of wait cycles. The access can also be held until an external ready line is high. A one-clock "cycle done" pulse marks the end of each access.

A 16-bit control word is written over a simple register bus and can be read back at any time. It holds four settings:
- the boundary code,
- the wait-cycle count,
- a ready-ignore flag,
- an address-disable flag, which drops the address-drive enable while the select is active.

The select is live straight out of reset and covers F0000h–FFFFFh, so the first instruction fetch at FFFF0h hits the region. A strap pin is sampled once as reset is released. If it is low at that moment, the address is always driven and the address-disable flag has no effect.

Top module: `umcs_unit`

## Requirements
- R1: After reset the read-back word is F03Bh. This means boundary code 111b, three wait cycles, external ready required and the address driven.
- R2: The boundary code sits in bits 14–12. Code 111b selects F0000h–FFFFFh, 110b selects E0000h–FFFFFh, 100b selects C0000h–FFFFFh and 000b selects 80000h–FFFFFh. An access to an address in the selected range holds `sel_n_o` low until its done pulse.
- R3: Bits 1–0 give the wait count W. With ready ignored, a hit access shows `cyc_done_o` in the (W+1)-th clock after the start strobe is sampled.
- R4: When bit 2 is 0, a hit access completes only when the wait cycles have elapsed and `ext_rdy_i` is high. When bit 2 is 1, `ext_rdy_i` has no effect on completion.
- R5: An access outside the region never lowers `sel_n_o`. It completes in the first clock after the start strobe, whatever the wait count and the ready line are.
- R6: `cyc_done_o` is high for exactly one clock per access, and `sel_n_o` returns high in the clock after it.
- R7: When bit 7 is 1 and the strap was high at reset release, `addr_drv_o` is low while `sel_n_o` is low. When bit 7 is 0, `addr_drv_o` stays high.
- R8: If `strap_i` is low at the rising edge of `rst_n`, `addr_drv_o` stays high regardless of bit 7. Changes of `strap_i` after that edge have no effect until the next reset.
- R9: Bit 15 and bits 5–3 always read 1, and bits 11–8 and bit 6 always read 0, whatever value was written to them.
- R10: An undefined boundary code is stored as the next smaller defined region. Code 101b becomes 110b, and codes 001b, 010b and 011b become 100b. Read-back shows the stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its rising edge samples the strap |
| strap_i | input | 1 | Strap; low at reset release forces the address to be driven |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 16 | Control register write data |
| reg_rdata_o | output | 16 | Control register read-back |
| cyc_start_i | input | 1 | Bus-cycle start strobe (ignored while an access is open) |
| cyc_addr_i | input | 20 | Address of the cycle, sampled with the start strobe |
| ext_rdy_i | input | 1 | External ready |
| sel_n_o | output | 1 | Active-low chip select |
| cyc_done_o | output | 1 | One-clock pulse ending an access |
| addr_drv_o | output | 1 | Address-drive enable |

## Verification
The assertions check the following on every cycle:
- the fixed reserved bits of the read-back word;
- that `cyc_done_o` never lasts two clocks;
- that the select holds until done;
- that the address enable is never dropped without a select or while the strap override is latched;
- that a ready-required hit never completes with the ready line low.

Some behaviours can only be shown by the bench's directed scenarios. These are the exact completion cycle for each wait count and ready delay, the four boundary ranges at both edges, the normalisation of undefined boundary codes, and the strap sampling across two resets.

// File: rtl/umcs_unit.sv
module umcs_unit #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_i,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          cyc_start_i,
  input  logic [AW-1:0] cyc_addr_i,
  input  logic          ext_rdy_i,
  output logic          sel_n_o,
  output logic          cyc_done_o,
  output logic          addr_drv_o
);
  logic [2:0] lb_q;
  logic       dis_q, ign_q, busy_q, hit_q, force_q;
  logic [1:0] ws_q, cnt_q;
  logic       hit;

  function automatic logic [2:0] norm_lb(input logic [2:0] c);
    if (c[2]) return (c[1:0] == 2'b11) ? 3'b111 : (c[1:0] == 2'b00 ? 3'b100 : 3'b110);
    else      return (c == 3'b000) ? 3'b000 : 3'b100;
  endfunction

  assign hit = cyc_addr_i[AW-1] & ((cyc_addr_i[AW-2:AW-4] & lb_q) == lb_q);
  assign reg_rdata_o = {1'b1, lb_q, 4'b0000, dis_q, 1'b0, 3'b111, ign_q, ws_q};
  assign cyc_done_o  = busy_q & (cnt_q == 2'd0) & (~hit_q | ign_q | ext_rdy_i);
  assign sel_n_o     = ~(busy_q & hit_q);
  assign addr_drv_o  = ~(busy_q & hit_q & dis_q & ~force_q);

  always_ff @(posedge rst_n) force_q <= ~strap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_q   <= 3'b111;
      dis_q  <= 1'b0;
      ign_q  <= 1'b0;
      ws_q   <= 2'd3;
      busy_q <= 1'b0;
      hit_q  <= 1'b0;
      cnt_q  <= 2'd0;
    end else begin
      if (reg_wr_i) begin
        lb_q  <= norm_lb(reg_wdata_i[14:12]);
        dis_q <= reg_wdata_i[7];
        ign_q <= reg_wdata_i[2];
        ws_q  <= reg_wdata_i[1:0];
      end
      if (!busy_q) begin
        if (cyc_start_i) begin
          busy_q <= 1'b1;
          hit_q  <= hit;
          cnt_q  <= hit ? ws_q : 2'd0;
        end
      end else if (cyc_done_o) begin
        busy_q <= 1'b0;
        hit_q  <= 1'b0;
      end else if (cnt_q != 2'd0) begin
        cnt_q <= cnt_q - 2'd1;
      end
    end
  end
endmodule

module umcs_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] reg_rdata_o,
  input logic        sel_n_o,
  input logic        cyc_done_o,
  input logic        addr_drv_o,
  input logic        ext_rdy_i,
  input logic        force_q
);
  // R9
  reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[15] && reg_rdata_o[11:8] == 4'b0 && !reg_rdata_o[6] && reg_rdata_o[5:3] == 3'b111);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done_o |=> !cyc_done_o);
  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n_o && !cyc_done_o) |=> !sel_n_o);
  // R7
  drv_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_o |-> addr_drv_o);
  // R8
  strap_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |-> addr_drv_o);
  // R4
  ready_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done_o && !sel_n_o && !reg_rdata_o[2]) |-> ext_rdy_i);
endmodule

bind umcs_unit umcs_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rdata_o(reg_rdata_o), .sel_n_o(sel_n_o),
  .cyc_done_o(cyc_done_o), .addr_drv_o(addr_drv_o), .ext_rdy_i(ext_rdy_i),
  .force_q(force_q)
);

// File: tb/umcs_unit_tb_top.sv
`timescale 1ns/1ps
module umcs_unit_tb_top;
  logic clk = 0, rst_n = 0, strap = 1, wr = 0, start = 0, rdy = 1;
  logic [15:0] wdata = 0, rdata;
  logic [19:0] addr = 0;
  logic sel_n, done, drv;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  umcs_unit dut_i (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cyc_start_i(start), .cyc_addr_i(addr), .ext_rdy_i(rdy),
    .sel_n_o(sel_n), .cyc_done_o(done), .addr_drv_o(drv)
  );

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cfg(input logic [2:0] lb, input logic dis, input logic ign, input logic [1:0] ws);
    return {1'b1, lb, 4'b0, dis, 1'b0, 3'b111, ign, ws};
  endfunction

  task automatic do_reset(input logic s);
    @(negedge clk); rst_n = 0; strap = s;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk); strap = ~s;
  endtask

  task automatic write(input logic [15:0] v);
    @(negedge clk); wr = 1; wdata = v;
    @(negedge clk); wr = 0;
  endtask

  // Runs one access; ready goes high from clock rdy_at after the start
  task automatic access(input string req, input logic [19:0] a, input int rdy_at,
                        input logic exp_hit, input int exp_cyc, input logic exp_drv);
    int n;
    logic saw_sel, saw_drv_low;
    @(negedge clk); start = 1; addr = a; rdy = (rdy_at <= 1);
    @(posedge clk); #1 start = 0;
    n = 1; saw_sel = 0; saw_drv_low = 0;
    for (int i = 0; i < 20; i++) begin
      rdy = (n >= rdy_at);
      #1;
      if (!sel_n) saw_sel = 1;
      if (!drv) saw_drv_low = 1;
      if (done) break;
      @(posedge clk); #1;
      n++;
    end
    check({req, " done cycle"}, n, exp_cyc);
    check({req, " select"}, saw_sel, exp_hit);
    check({req, " addr drive"}, !saw_drv_low, exp_drv);
    @(posedge clk); #1;
    check("R6 done one clock", done, 0);
    check("R6 select released", sel_n, 1);
    rdy = 1;
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    @(negedge clk);
    check("R1 reset word", rdata, 16'hF03B);
    check("R1 sel idle", sel_n, 1);
    access("R1 first fetch FFFF0", 20'hFFFF0, 1, 1, 4, 1);
  endtask

  task automatic t_regions;
    write(cfg(3'b111, 0, 1, 0));
    access("R2 64K low edge", 20'hF0000, 1, 1, 1, 1);
    access("R2 64K below", 20'hEFFFF, 1, 0, 1, 1);
    write(cfg(3'b110, 0, 1, 0));
    access("R2 128K low edge", 20'hE0000, 1, 1, 1, 1);
    access("R2 128K below", 20'hDFFFF, 1, 0, 1, 1);
    write(cfg(3'b100, 0, 1, 0));
    access("R2 256K low edge", 20'hC0000, 1, 1, 1, 1);
    access("R2 256K below", 20'hBFFFF, 1, 0, 1, 1);
    write(cfg(3'b000, 0, 1, 0));
    access("R2 512K low edge", 20'h80000, 1, 1, 1, 1);
    access("R2 top", 20'hFFFFF, 1, 1, 1, 1);
    access("R5 512K below", 20'h7FFFF, 1, 0, 1, 1);
  endtask

  task automatic t_waits;
    for (int w = 0; w < 4; w++) begin
      write(cfg(3'b111, 0, 1, w[1:0]));
      access("R3 wait count", 20'hF1234, 9, 1, w + 1, 1);
    end
  endtask

  task automatic t_ready;
    write(cfg(3'b111, 0, 0, 1));
    access("R4 late ready", 20'hF8000, 5, 1, 5, 1);
    access("R4 early ready", 20'hF8000, 1, 1, 2, 1);
    write(cfg(3'b111, 0, 1, 1));
    access("R4 ready ignored", 20'hF8000, 7, 1, 2, 1);
    write(cfg(3'b111, 0, 0, 3));
    access("R5 miss no wait", 20'h12345, 6, 0, 1, 1);
  endtask

  task automatic t_addr_disable;
    write(cfg(3'b111, 1, 1, 1));
    access("R7 disable drops drive", 20'hF0010, 1, 1, 2, 0);
    access("R7 miss keeps drive", 20'h00010, 1, 0, 1, 1);
    write(cfg(3'b111, 0, 1, 1));
    access("R7 enable keeps drive", 20'hF0010, 1, 1, 2, 1);
  endtask

  task automatic t_strap;
    do_reset(1'b0);
    write(cfg(3'b111, 1, 1, 1));
    access("R8 strap forces drive", 20'hF0010, 1, 1, 2, 1);
    do_reset(1'b1);
    write(cfg(3'b111, 1, 1, 1));
    access("R8 strap high allows disable", 20'hF0010, 1, 1, 2, 0);
  endtask

  task automatic t_reserved;
    write(16'h0FFF);
    @(negedge clk);
    check("R9 reserved read", rdata, 16'h80BF);
    write(16'h7F40);
    @(negedge clk);
    check("R9 reserved discard", rdata, 16'hF038);
  endtask

  task automatic t_norm;
    write(cfg(3'b101, 0, 1, 0));
    @(negedge clk); check("R10 101 stored", rdata[14:12], 3'b110);
    access("R10 101 as 128K", 20'hE0000, 1, 1, 1, 1);
    write(cfg(3'b011, 0, 1, 0));
    @(negedge clk); check("R10 011 stored", rdata[14:12], 3'b100);
    access("R10 011 as 256K in", 20'hC0000, 1, 1, 1, 1);
    access("R10 011 as 256K out", 20'hBFFF0, 1, 0, 1, 1);
    write(cfg(3'b001, 0, 1, 0));
    @(negedge clk); check("R10 001 stored", rdata[14:12], 3'b100);
  endtask

  initial begin
    t_reset();
    t_regions();
    t_waits();
    t_ready();
    t_addr_disable();
    t_strap();
    t_reserved();
    t_norm();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule